// File: doc/BRIEF.md
# Cache Bus Master IO Sequencer

This block is the master-side sequencer that a cache uses to carry out uncached IO reads and IO writes on the memory bus for a request raised on the processor bus. While no request is pending it runs a two-state idle loop. In that loop it drives the no-op bus command, keeps the address-fetch and refresh requests up, and signals done. When it sees a request it runs a fixed four-cycle transaction. The cycles are address fetch, command and address phase, bus release with the completion strobe, and a trailing no-op cycle. It then returns to idle.

The trailing cycle exists so that the processor request is sampled again only after completion has been seen. Without it, one request could be serviced twice. Processor sampling is suppressed on the release and trailing cycles, and the request input is ignored on every transaction cycle. The direction of the transfer is latched when the request is accepted.

States: IDLE_A and IDLE_B (the idle loop), FETCH (cycle 0), COMMAND (cycle 1), RELEASE (cycle 2) and TRAIL (cycle 3). Transitions:
- IDLE_TOGGLE: IDLE_A goes to IDLE_B and back when there is no request.
- ACCEPT: either idle state goes to FETCH when a request is present.
- ADVANCE: FETCH goes to COMMAND, then to RELEASE, then to TRAIL.
- FINISH: TRAIL goes to IDLE_A.

All outputs are decoded from the state and the latched direction only.

Top module: `io_bus_sequencer`

## Requirements
- R1: An asynchronous active-low reset puts the block in IDLE_A. While reset is held and in the cycle after it, the outputs read: `bus_cmd`=15, `addr_fetch`=1, `refresh_req`=1, `seq_done`=1, and every other output 0.
- R2: While `req_valid` is low at each rising edge, the block stays in the idle loop and shows the R1 output values on every cycle.
- R3: A high `req_valid` at a rising edge in either idle state starts a transaction. In the next cycle (FETCH) only `addr_fetch` is high, and `bus_cmd`=15.
- R4: In COMMAND, `bus_cmd` is 5 for a read or 7 for a write. `addr_drive`, `seq_done`, `force_slave`, `force_idle` and `refresh_req` are high, and `bus_release`, `xfer_complete` and `suppress_sample` are low.
- R5: In COMMAND of a write, `ram_load_left` and `wdata_drive_dly` are high. In a read they stay low, and they are low in every other state.
- R6: In RELEASE, `bus_cmd`=15 and `bus_release`, `xfer_complete`, `suppress_sample` and `refresh_req` are high, while `addr_drive` and `seq_done` are low. `ram_to_pdata` is high in a read and low in a write.
- R7: In TRAIL, `bus_cmd`=15 and `suppress_sample`, `seq_done` and `refresh_req` are high, while `xfer_complete` and `bus_release` are low.
- R8: `req_valid` is ignored in FETCH through TRAIL, and TRAIL always goes to IDLE_A. A request held high therefore gets exactly one `xfer_complete` pulse per transaction, and at least one idle cycle lies between TRAIL and the next FETCH.
- R9: `req_is_write` is sampled only at the accepting edge (1 = write, 0 = read). Changes to it during a transaction do not affect that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor-bus IO request pending |
| req_is_write | input | 1 | Direction of the pending request, 1 = write |
| addr_fetch | output | 1 | Fetch the target address |
| refresh_req | output | 1 | Refresh request |
| seq_done | output | 1 | Sequencer step done |
| force_slave | output | 1 | Force the slave path |
| force_idle | output | 1 | Force the idle sequence |
| addr_drive | output | 1 | Drive page and low address bits as bus data |
| wdata_drive_dly | output | 1 | Delayed drive enable for the write data |
| ram_load_left | output | 1 | Load the left half of processor data into the RAM register |
| bus_release | output | 1 | Release the memory bus |
| xfer_complete | output | 1 | Completion strobe to the processor bus |
| suppress_sample | output | 1 | Block processor-bus request sampling |
| ram_to_pdata | output | 1 | Return the RAM register to processor data |
| bus_cmd | output | CMD_W | Memory bus command code |

## Verification
The bound checker watches several properties on every cycle:
- the completion strobe always comes with bus release and sampling suppression, and is followed by one trailing cycle with no second strobe;
- every non-no-op command is followed by the strobe;
- an address fetch is followed by the command phase;
- the idle loop holds while no request arrives;
- the write-only enables appear only with the write command.

Only the bench scenarios show the rest: the exact output set of each cycle, a request held across a transaction waiting for the idle state, a direction change ignored mid-transaction, and a reset taken in the middle of a transfer.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_A  = 3'd0,
        ST_IDLE_B  = 3'd1,
        ST_FETCH   = 3'd2,
        ST_COMMAND = 3'd3,
        ST_RELEASE = 3'd4,
        ST_TRAIL   = 3'd5
    } seq_state_e;

    function automatic logic is_idle(input seq_state_e s);
        return (s == ST_IDLE_A) || (s == ST_IDLE_B);
    endfunction

endpackage

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
    import io_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output seq_state_e state,
    output logic       accept
);

    seq_state_e state_nxt;

    assign accept = is_idle(state) && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE_A;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE_A:  state_nxt = req_valid ? ST_FETCH : ST_IDLE_B;
            ST_IDLE_B:  state_nxt = req_valid ? ST_FETCH : ST_IDLE_A;
            ST_FETCH:   state_nxt = ST_COMMAND;
            ST_COMMAND: state_nxt = ST_RELEASE;
            ST_RELEASE: state_nxt = ST_TRAIL;
            ST_TRAIL:   state_nxt = ST_IDLE_A;
            default:    state_nxt = ST_IDLE_A;
        endcase
    end

endmodule

// File: rtl/io_seq_dir_latch.sv
module io_seq_dir_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic req_is_write,
    output logic is_write
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_write <= 1'b0;
        end else if (accept) begin
            is_write <= req_is_write;
        end
    end

endmodule

// File: rtl/io_seq_decode.sv
module io_seq_decode
    import io_seq_pkg::*;
#(
    parameter int unsigned CMD_W    = 4,
    parameter int unsigned CMD_NOOP = 15,
    parameter int unsigned CMD_IORD = 5,
    parameter int unsigned CMD_IOWR = 7
) (
    input  seq_state_e       state,
    input  logic             is_write,
    output logic             addr_fetch,
    output logic             refresh_req,
    output logic             seq_done,
    output logic             force_slave,
    output logic             force_idle,
    output logic             addr_drive,
    output logic             wdata_drive_dly,
    output logic             ram_load_left,
    output logic             bus_release,
    output logic             xfer_complete,
    output logic             suppress_sample,
    output logic             ram_to_pdata,
    output logic [CMD_W-1:0] bus_cmd
);

    localparam logic [CMD_W-1:0] NOOP_CODE = CMD_W'(CMD_NOOP);
    localparam logic [CMD_W-1:0] RD_CODE   = CMD_W'(CMD_IORD);
    localparam logic [CMD_W-1:0] WR_CODE   = CMD_W'(CMD_IOWR);

    always_comb begin
        addr_fetch      = 1'b0;
        refresh_req     = 1'b0;
        seq_done        = 1'b0;
        force_slave     = 1'b0;
        force_idle      = 1'b0;
        addr_drive      = 1'b0;
        wdata_drive_dly = 1'b0;
        ram_load_left   = 1'b0;
        bus_release     = 1'b0;
        xfer_complete   = 1'b0;
        suppress_sample = 1'b0;
        ram_to_pdata    = 1'b0;
        bus_cmd         = NOOP_CODE;
        unique case (state)
            ST_IDLE_A, ST_IDLE_B: begin
                addr_fetch  = 1'b1;
                refresh_req = 1'b1;
                seq_done    = 1'b1;
            end
            ST_FETCH: begin
                addr_fetch = 1'b1;
            end
            ST_COMMAND: begin
                bus_cmd         = is_write ? WR_CODE : RD_CODE;
                addr_drive      = 1'b1;
                seq_done        = 1'b1;
                force_slave     = 1'b1;
                force_idle      = 1'b1;
                refresh_req     = 1'b1;
                ram_load_left   = is_write;
                wdata_drive_dly = is_write;
            end
            ST_RELEASE: begin
                refresh_req     = 1'b1;
                bus_release     = 1'b1;
                xfer_complete   = 1'b1;
                suppress_sample = 1'b1;
                ram_to_pdata    = !is_write;
            end
            ST_TRAIL: begin
                refresh_req     = 1'b1;
                suppress_sample = 1'b1;
                seq_done        = 1'b1;
            end
            default: begin
                bus_cmd = NOOP_CODE;
            end
        endcase
    end

endmodule

// File: rtl/io_bus_sequencer.sv
module io_bus_sequencer
    import io_seq_pkg::*;
#(
    parameter int unsigned CMD_W    = 4,
    parameter int unsigned CMD_NOOP = 15,
    parameter int unsigned CMD_IORD = 5,
    parameter int unsigned CMD_IOWR = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_is_write,
    output logic             addr_fetch,
    output logic             refresh_req,
    output logic             seq_done,
    output logic             force_slave,
    output logic             force_idle,
    output logic             addr_drive,
    output logic             wdata_drive_dly,
    output logic             ram_load_left,
    output logic             bus_release,
    output logic             xfer_complete,
    output logic             suppress_sample,
    output logic             ram_to_pdata,
    output logic [CMD_W-1:0] bus_cmd
);

    seq_state_e state;
    logic       accept;
    logic       is_write;

    io_seq_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .state     (state),
        .accept    (accept)
    );

    io_seq_dir_latch i_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .req_is_write (req_is_write),
        .is_write     (is_write)
    );

    io_seq_decode #(
        .CMD_W    (CMD_W),
        .CMD_NOOP (CMD_NOOP),
        .CMD_IORD (CMD_IORD),
        .CMD_IOWR (CMD_IOWR)
    ) i_dec (
        .state           (state),
        .is_write        (is_write),
        .addr_fetch      (addr_fetch),
        .refresh_req     (refresh_req),
        .seq_done        (seq_done),
        .force_slave     (force_slave),
        .force_idle      (force_idle),
        .addr_drive      (addr_drive),
        .wdata_drive_dly (wdata_drive_dly),
        .ram_load_left   (ram_load_left),
        .bus_release     (bus_release),
        .xfer_complete   (xfer_complete),
        .suppress_sample (suppress_sample),
        .ram_to_pdata    (ram_to_pdata),
        .bus_cmd         (bus_cmd)
    );

endmodule

// File: rtl/io_bus_sequencer_chk.sv
module io_bus_sequencer_chk #(
    parameter int unsigned CMD_W    = 4,
    parameter int unsigned CMD_NOOP = 15,
    parameter int unsigned CMD_IOWR = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             addr_fetch,
    input logic             refresh_req,
    input logic             seq_done,
    input logic             addr_drive,
    input logic             wdata_drive_dly,
    input logic             ram_load_left,
    input logic             bus_release,
    input logic             xfer_complete,
    input logic             suppress_sample,
    input logic [CMD_W-1:0] bus_cmd
);

    localparam logic [CMD_W-1:0] NOOP_CODE = CMD_W'(CMD_NOOP);
    localparam logic [CMD_W-1:0] WR_CODE   = CMD_W'(CMD_IOWR);

    // R6
    release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_complete |-> (bus_release && suppress_sample && !addr_drive && bus_cmd == NOOP_CODE));

    // R4
    cmd_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != NOOP_CODE) |=> xfer_complete);

    // R7
    trail_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_complete |=> (!xfer_complete && suppress_sample && seq_done && bus_cmd == NOOP_CODE));

    // R8
    trail_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress_sample && !xfer_complete) |=> (!suppress_sample && addr_fetch && refresh_req));

    // R3
    fetch_then_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_fetch && !refresh_req) |=> (bus_cmd != NOOP_CODE && addr_drive));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_fetch && refresh_req && !req_valid) |=> (addr_fetch && refresh_req && seq_done));

    // R5
    write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_drive_dly || ram_load_left) |-> (bus_cmd == WR_CODE));

endmodule

bind io_bus_sequencer io_bus_sequencer_chk #(
    .CMD_W    (CMD_W),
    .CMD_NOOP (CMD_NOOP),
    .CMD_IOWR (CMD_IOWR)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .addr_fetch      (addr_fetch),
    .refresh_req     (refresh_req),
    .seq_done        (seq_done),
    .addr_drive      (addr_drive),
    .wdata_drive_dly (wdata_drive_dly),
    .ram_load_left   (ram_load_left),
    .bus_release     (bus_release),
    .xfer_complete   (xfer_complete),
    .suppress_sample (suppress_sample),
    .bus_cmd         (bus_cmd)
);

// File: tb/test_io_bus_sequencer.sv
module test_io_bus_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_is_write = 1'b0;
    logic       addr_fetch, refresh_req, seq_done, force_slave, force_idle;
    logic       addr_drive, wdata_drive_dly, ram_load_left, bus_release;
    logic       xfer_complete, suppress_sample, ram_to_pdata;
    logic [3:0] bus_cmd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    io_bus_sequencer i_io_bus_sequencer (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_is_write    (req_is_write),
        .addr_fetch      (addr_fetch),
        .refresh_req     (refresh_req),
        .seq_done        (seq_done),
        .force_slave     (force_slave),
        .force_idle      (force_idle),
        .addr_drive      (addr_drive),
        .wdata_drive_dly (wdata_drive_dly),
        .ram_load_left   (ram_load_left),
        .bus_release     (bus_release),
        .xfer_complete   (xfer_complete),
        .suppress_sample (suppress_sample),
        .ram_to_pdata    (ram_to_pdata),
        .bus_cmd         (bus_cmd)
    );

    // Bundle layout: [15] addr_fetch [14] refresh [13] done [12] force_slave
    // [11] force_idle [10] addr_drive [9] wdata_drive_dly [8] ram_load_left
    // [7] bus_release [6] xfer_complete [5] suppress [4] ram_to_pdata [3:0] cmd
    localparam logic [15:0] E_IDLE   = 16'hE00F;
    localparam logic [15:0] E_FETCH  = 16'h800F;
    localparam logic [15:0] E_CMD_RD = 16'h7C05;
    localparam logic [15:0] E_CMD_WR = 16'h7F07;
    localparam logic [15:0] E_REL_RD = 16'h40FF;
    localparam logic [15:0] E_REL_WR = 16'h40EF;
    localparam logic [15:0] E_TRAIL  = 16'h602F;

    // Entry: {req_valid, req_is_write, expected bundle after the edge, requirement}
    localparam int NVEC = 30;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2 idle loop
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2
        {1'b1, 1'b0, E_FETCH,  4'd3},  // R3 accept read
        {1'b0, 1'b1, E_CMD_RD, 4'd9},  // R9 direction change ignored
        {1'b1, 1'b1, E_REL_RD, 4'd6},  // R6 read release
        {1'b1, 1'b1, E_TRAIL,  4'd7},  // R7 trailing cycle
        {1'b0, 1'b0, E_IDLE,   4'd8},  // R8 back to idle
        {1'b1, 1'b1, E_FETCH,  4'd3},  // R3 accept write
        {1'b1, 1'b0, E_CMD_WR, 4'd5},  // R5 write extras
        {1'b1, 1'b0, E_REL_WR, 4'd6},  // R6 write release
        {1'b1, 1'b0, E_TRAIL,  4'd7},  // R7
        {1'b1, 1'b1, E_IDLE,   4'd8},  // R8 held request waits for idle
        {1'b1, 1'b1, E_FETCH,  4'd8},  // R8 sampled in idle
        {1'b0, 1'b0, E_CMD_WR, 4'd9},  // R9 latched write
        {1'b0, 1'b0, E_REL_WR, 4'd6},  // R6
        {1'b0, 1'b0, E_TRAIL,  4'd7},  // R7
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2
        {1'b1, 1'b0, E_FETCH,  4'd3},  // R3
        {1'b0, 1'b0, E_CMD_RD, 4'd4},  // R4 read command
        {1'b0, 1'b0, E_REL_RD, 4'd6},  // R6
        {1'b0, 1'b0, E_TRAIL,  4'd7},  // R7
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2
        {1'b0, 1'b0, E_IDLE,   4'd2},  // R2 other idle state
        {1'b1, 1'b1, E_FETCH,  4'd3},  // R3 accept from the other idle state
        {1'b1, 1'b1, E_CMD_WR, 4'd4},  // R4 write command
        {1'b0, 1'b0, E_REL_WR, 4'd6},  // R6
        {1'b1, 1'b0, E_TRAIL,  4'd7},  // R7
        {1'b0, 1'b0, E_IDLE,   4'd8}   // R8
    };

    function automatic logic [15:0] bundle();
        return {addr_fetch, refresh_req, seq_done, force_slave, force_idle,
                addr_drive, wdata_drive_dly, ram_load_left, bus_release,
                xfer_complete, suppress_sample, ram_to_pdata, bus_cmd};
    endfunction

    task automatic check(input logic [15:0] exp, input int req, input string what);
        checks++;
        if (bundle() !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, bundle(), exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(E_IDLE, 1, "R1 outputs while reset held");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(E_IDLE, 1, "R1 first cycle after reset");

        for (int i = 0; i < NVEC; i++) begin
            req_valid    = VEC[i][21];
            req_is_write = VEC[i][20];
            @(posedge clk);
            @(negedge clk);
            check(VEC[i][19:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
        end

        // R1: reset in the middle of a write transfer
        req_valid = 1'b1;
        req_is_write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(E_FETCH, 3, "R3 fetch before reset");
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(E_CMD_WR, 5, "R5 command before reset");
        rst_n = 1'b0;
        #1;
        check(E_IDLE, 1, "R1 async reset mid-transfer");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(E_IDLE, 1, "R1 idle after mid-transfer reset");

        // R9: direction reset to read; a read accepted after reset must not reuse the write
        req_valid = 1'b1;
        req_is_write = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_is_write = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(E_CMD_RD, 9, "R9 read after reset");
        @(posedge clk);
        @(negedge clk);
        check(E_REL_RD, 6, "R6 read release after reset");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule